// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded-clock lane for a display link. A pixel clock strobes each word into the block, either on its rising or its falling edge as chosen by a static select input. A second clock, frequency-locked at seven times the pixel rate and generated outside the block, shifts each lane out one bit per cycle. Each pixel word therefore fills exactly one seven-bit slot on every lane.

A free-running modulo-7 position counter on the bit clock marks the slot boundaries. It also produces the forwarded clock, which is low for three positions and high for four, so every slot starts where the forwarded clock falls. An active-low power-down input clears all state and holds every serial output low.

The bit clock must be phase-offset from the pixel clock so that no capture edge lands on the bit-clock edge that loads the shift registers. The wiring of that clock is the integrator's job.

Top module: `ser7_link_tx`

## Requirements
- R1: Lane k (`lane_ser[k]`, k = 0..3) carries input bits `pix_data[7k+6:7k]`, so lane 0 has bits 0 to 6 and lane 3 has bits 21 to 27.
- R2: Within a slot, position p (0 first, 6 last) of lane k carries `pix_data[7k+p]`, so the lowest index is sent first.
- R3: With `edge_sel` = 1 the word is captured on the rising edge of `pix_clk`. With `edge_sel` = 0 it is captured on the falling edge.
- R4: A slot lasts exactly 7 `bit_clk` cycles. All four lanes carry the same captured word in the same slot, and successive captured words occupy successive slots, with none dropped or repeated.
- R5: The levels of `fclk_ser` at positions 0..6 are 0,0,0,1,1,1,1. That gives a 7-cycle period with four cycles high.
- R6: Position 0 of every slot begins at a falling edge of `fclk_ser`. The first slot after power-down is released is the only exception: it begins at the release.
- R7: While `pd_n` is low, the lanes, the forwarded clock and the position counter are cleared at every `bit_clk` rising edge, and the capture registers are cleared at the capture edges. From the first `bit_clk` edge after assertion, every serial output is low.
- R8: On release of `pd_n`, the first `bit_clk` cycle is position 0. The whole first slot carries zeros on every lane.
- R9: The delay from a word's capture to its slot is a fixed number of pixel periods. It stays constant for as long as power-down stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| pix_clk | input | 1 | Pixel clock that strobes the parallel word |
| pd_n | input | 1 | Active-low power-down and clear |
| edge_sel | input | 1 | Capture edge: 1 selects rising, 0 selects falling |
| pix_data | input | 28 | Parallel pixel word |
| lane_ser | output | 4 | Serial data lanes, lane k at bit k |
| fclk_ser | output | 1 | Forwarded clock pattern at the pixel rate |

## Verification
The bench drives a different word in each half of the pixel period. The word held around the rising edge and the word held around the falling edge are unrelated, so a recovered stream matches only one of the two sequences, and that proves which edge captured it. Random 28-bit words are mixed with directed words: all ones, a single low bit, a single high bit, the two alternating patterns, and a word confined to one lane. Between them these separate lane swaps, reversed bit order and stuck bits. Each lane is deserialized from the slot start, and the bench checks the clock pattern and the constant word lag. It also checks the all-zero first slot and the quiet outputs across several power-down periods, one of which includes an edge-select change.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

    localparam int DEF_LANES      = 4;
    localparam int DEF_SLOT       = 7;
    localparam int DEF_HIGH_SLOTS = 4;

    typedef enum logic {
        CAP_FALL = 1'b0,
        CAP_RISE = 1'b1
    } cap_edge_e;

    // Forwarded-clock level for a given slot position: low first, high for the last `high` positions.
    function automatic logic fclk_level(int pos, int slot, int high);
        return (pos >= (slot - high));
    endfunction

    // Next slot position, wrapping at the slot length.
    function automatic int next_pos(int pos, int slot);
        return (pos == slot - 1) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/ser7_capture.sv
module ser7_capture
    import ser7_pkg::*;
#(
    parameter int WIDTH = DEF_LANES * DEF_SLOT
) (
    input  logic             pix_clk,
    input  logic             pd_n,
    input  logic             edge_sel,
    input  logic [WIDTH-1:0] pix_data,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] fall_q;
    cap_edge_e        sel;

    assign sel = cap_edge_e'(edge_sel);

    always_ff @(posedge pix_clk) begin
        if (!pd_n) rise_q <= '0;
        else       rise_q <= pix_data;
    end

    always_ff @(negedge pix_clk) begin
        if (!pd_n) fall_q <= '0;
        else       fall_q <= pix_data;
    end

    always_comb begin
        unique case (sel)
            CAP_RISE: word_o = rise_q;
            default:  word_o = fall_q;
        endcase
    end

endmodule

// File: rtl/ser7_phase.sv
module ser7_phase
    import ser7_pkg::*;
#(
    parameter int SLOT       = DEF_SLOT,
    parameter int HIGH_SLOTS = DEF_HIGH_SLOTS,
    localparam int PH_W      = $clog2(SLOT)
) (
    input  logic            bit_clk,
    input  logic            pd_n,
    output logic [PH_W-1:0] pos_o,
    output logic            load_o,
    output logic            fclk_o
);

    logic [PH_W-1:0] nxt;

    assign nxt    = PH_W'(next_pos(int'(pos_o), SLOT));
    assign load_o = (pos_o == PH_W'(SLOT - 1));

    always_ff @(posedge bit_clk) begin
        if (!pd_n) begin
            pos_o  <= '0;
            fclk_o <= 1'b0;
        end else begin
            pos_o  <= nxt;
            fclk_o <= fclk_level(int'(nxt), SLOT, HIGH_SLOTS);
        end
    end

    // R4: a slot closes after its last position
    a_r4_slot_wrap: assert property (@(posedge bit_clk) disable iff (!pd_n)
        (pos_o == PH_W'(SLOT - 1)) |=> (pos_o == '0));

    // R6: the forwarded clock only falls where a slot begins
    a_r6_fall_at_start: assert property (@(posedge bit_clk) disable iff (!pd_n)
        $fell(fclk_o) |-> (pos_o == '0));

    // R5: the forwarded clock rises where the high stretch begins
    a_r5_rise_pos: assert property (@(posedge bit_clk) disable iff (!pd_n)
        $rose(fclk_o) |-> (pos_o == PH_W'(SLOT - HIGH_SLOTS)));

endmodule

// File: rtl/ser7_lane.sv
module ser7_lane #(
    parameter int SLOT = 7
) (
    input  logic            bit_clk,
    input  logic            pd_n,
    input  logic            load_i,
    input  logic [SLOT-1:0] bits_i,
    output logic            ser_o
);

    logic [SLOT-1:0] sh;

    always_ff @(posedge bit_clk) begin
        if (!pd_n)       sh <= '0;
        else if (load_i) sh <= bits_i;
        else             sh <= {1'b0, sh[SLOT-1:1]};
    end

    assign ser_o = sh[0];

    // R2: the position after the first carries the next higher bit of the group
    a_r2_second_bit: assert property (@(posedge bit_clk) disable iff (!pd_n)
        ($past(pd_n, 2) && $past(pd_n) && $past(load_i, 2)) |-> (ser_o == $past(bits_i[1], 2)));

endmodule

// File: rtl/ser7_link_tx.sv
module ser7_link_tx
    import ser7_pkg::*;
#(
    parameter int LANES      = DEF_LANES,
    parameter int SLOT       = DEF_SLOT,
    parameter int HIGH_SLOTS = DEF_HIGH_SLOTS,
    localparam int WIDTH     = LANES * SLOT,
    localparam int PH_W      = $clog2(SLOT)
) (
    input  logic             bit_clk,
    input  logic             pix_clk,
    input  logic             pd_n,
    input  logic             edge_sel,
    input  logic [WIDTH-1:0] pix_data,
    output logic [LANES-1:0] lane_ser,
    output logic             fclk_ser
);

    logic [WIDTH-1:0] word;
    logic [PH_W-1:0]  pos;
    logic             load;

    ser7_capture #(.WIDTH(WIDTH)) u_capture (
        .pix_clk  (pix_clk),
        .pd_n     (pd_n),
        .edge_sel (edge_sel),
        .pix_data (pix_data),
        .word_o   (word)
    );

    ser7_phase #(.SLOT(SLOT), .HIGH_SLOTS(HIGH_SLOTS)) u_phase (
        .bit_clk (bit_clk),
        .pd_n    (pd_n),
        .pos_o   (pos),
        .load_o  (load),
        .fclk_o  (fclk_ser)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ser7_lane #(.SLOT(SLOT)) u_lane (
            .bit_clk (bit_clk),
            .pd_n    (pd_n),
            .load_i  (load),
            .bits_i  (word[l*SLOT +: SLOT]),
            .ser_o   (lane_ser[l])
        );

        // R1: at slot start each lane shows the lowest bit of its own group of the loaded word
        a_r1_lane_map: assert property (@(posedge bit_clk) disable iff (!pd_n)
            ($past(pd_n) && (pos == '0)) |-> (lane_ser[l] == $past(word[l*SLOT])));
    end

    // R7: one edge after power-down is seen, every serial output is low
    a_r7_quiet: assert property (@(posedge bit_clk)
        $past(!pd_n) |-> ((lane_ser == '0) && !fclk_ser));

endmodule

// File: tb/ser7_link_tx_tb.sv
module ser7_link_tx_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANES = 4;
    localparam int SLOT  = 7;
    localparam int W     = LANES * SLOT;
    localparam int DEPTH = 1024;

    logic           bit_clk = 1'b0;
    logic           pix_clk = 1'b0;
    logic           pd_n    = 1'b0;
    logic           edge_sel = 1'b1;
    logic [W-1:0]   pix_data = '0;
    logic [LANES-1:0] lane_ser;
    logic           fclk_ser;

    int nchecks = 0;
    int nerrs   = 0;
    bit done    = 1'b0;

    logic [W-1:0] app_a [DEPTH];
    logic [W-1:0] app_b [DEPTH];
    int na = 0;
    int nb = 0;
    int gcnt = 0;

    bit   prev_pd = 1'b0;
    bit   active  = 1'b0;
    bit   aligned = 1'b0;
    logic prev_f  = 1'b0;
    int   pos = 0;
    int   slotn = 0;
    int   lastj = 0;
    int   lag = 0;
    logic [W-1:0]      acc = '0;
    logic [SLOT-1:0]   fpat = '0;

    ser7_link_tx u_dut (
        .bit_clk  (bit_clk),
        .pix_clk  (pix_clk),
        .pd_n     (pd_n),
        .edge_sel (edge_sel),
        .pix_data (pix_data),
        .lane_ser (lane_ser),
        .fclk_ser (fclk_ser)
    );

    // 200 MHz bit clock; pixel clock at one seventh, offset by a quarter bit period
    always #2.5 bit_clk = ~bit_clk;
    initial begin
        #1.25;
        forever #17.5 pix_clk = ~pix_clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        nchecks++;
        if (!ok) begin
            nerrs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [SLOT-1:0] exp_fclk_pattern();
        logic [SLOT-1:0] p;
        for (int i = 0; i < SLOT; i++) p[i] = (i >= SLOT - 4);
        return p;
    endfunction

    function automatic logic [W-1:0] gen_word(int n);
        logic [W-1:0] v;
        case (n % 32)
            0: v = 28'hFFF_FFFF;
            1: v = 28'hFFF_FFFE;
            2: v = 28'h800_0000;
            3: v = 28'h555_5555;
            4: v = 28'hAAA_AAAA;
            5: v = 28'h000_007F;
            6: v = 28'hFE0_0000;
            7: v = 28'h000_3F80;
            default: v = W'($urandom);
        endcase
        if (v == '0) v = 28'h000_0001;
        return v;
    endfunction

    // One word is held around each rising edge, another around each falling edge
    always @(posedge pix_clk) begin
        app_a[na % DEPTH] = pix_data;
        na++;
        #8;
        pix_data = gen_word(gcnt);
        gcnt++;
    end
    always @(negedge pix_clk) begin
        app_b[nb % DEPTH] = pix_data;
        nb++;
        #8;
        pix_data = gen_word(gcnt);
        gcnt++;
    end

    task automatic finish_slot();
        int latest;
        bit found;
        logic [W-1:0] e;
        chk(fpat == exp_fclk_pattern(), "R5", "forwarded clock pattern", W'(fpat), W'(exp_fclk_pattern()));
        latest = (edge_sel ? na : nb) - 1;
        if (slotn == 0) begin
            chk(acc == '0, "R8", "first slot after release", acc, '0);
        end else if (!aligned) begin
            if (acc == '0) begin
                if (slotn > 2) chk(1'b0, "R4", "no word reached the lanes", acc, '1);
            end else begin
                found = 1'b0;
                for (int j = latest; j > latest - 4 && j >= 0; j--) begin
                    e = edge_sel ? app_a[j % DEPTH] : app_b[j % DEPTH];
                    if (!found && e == acc) begin
                        found = 1'b1;
                        lastj = j;
                        lag   = latest - j;
                    end
                end
                chk(found, edge_sel ? "R3 rising" : "R3 falling", "word not captured on chosen edge", acc, '0);
                aligned = found;
            end
        end else begin
            lastj++;
            e = edge_sel ? app_a[lastj % DEPTH] : app_b[lastj % DEPTH];
            chk(acc == e, "R1 R2 R4", "recovered word", acc, e);
            chk((latest - lastj) == lag, "R9", "capture-to-slot lag", W'(latest - lastj), W'(lag));
        end
    endtask

    // Deserializer: samples away from the active bit-clock edge
    always @(negedge bit_clk) begin
        if (!pd_n) begin
            active = 1'b0;
            if (!prev_pd)
                chk((lane_ser == '0) && !fclk_ser, "R7", "outputs during power-down",
                    W'({fclk_ser, lane_ser}), '0);
        end else begin
            if (!prev_pd) begin
                active  = 1'b1;
                pos     = 0;
                slotn   = 0;
                aligned = 1'b0;
                acc     = '0;
            end
            if (active) begin
                for (int l = 0; l < LANES; l++) acc[l*SLOT + pos] = lane_ser[l];
                fpat[pos] = fclk_ser;
                if (pos == 0 && slotn > 0)
                    chk(prev_f && !fclk_ser, "R6", "slot start not at clock fall",
                        W'({prev_f, fclk_ser}), W'(2'b10));
                if (pos == SLOT - 1) begin
                    finish_slot();
                    slotn++;
                    pos = 0;
                end else begin
                    pos++;
                end
            end
            prev_f = fclk_ser;
        end
        prev_pd = pd_n;
    end

    task automatic run_phase(input bit es, input int periods);
        @(posedge bit_clk); #1;
        pd_n = 1'b0;
        repeat (6) @(posedge pix_clk);
        edge_sel = es;
        repeat (4) @(posedge pix_clk);
        @(negedge bit_clk); #0.5;
        chk((lane_ser == '0) && !fclk_ser, "R7", "quiet before release", W'({fclk_ser, lane_ser}), '0);
        @(posedge bit_clk); #1;
        pd_n = 1'b1;
        repeat (periods) @(posedge pix_clk);
        chk(aligned, es ? "R3 rising" : "R3 falling", "stream never aligned", W'(aligned), W'(1));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge pix_clk);
        @(negedge bit_clk); #0.5;
        chk((lane_ser == '0) && !fclk_ser, "R7", "reset state", W'({fclk_ser, lane_ser}), '0);
        run_phase(1'b1, 120);
        run_phase(1'b0, 120);
        run_phase(1'b1, 60);
        @(posedge bit_clk); #1;
        pd_n = 1'b0;
        repeat (3) @(posedge pix_clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            nchecks++;
            nerrs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
            $finish;
        end
    end

endmodule